// File: doc/BRIEF.md
# Noise-guess search core

This block is the search engine of a soft-input decoder that works with any linear block code. It does not decode the code. It guesses the noise. A hard-decision word arrives together with its syndrome and a permutation. The permutation gives, for each reliability rank, the bit position that holds that rank. Rank 1 is the least reliable bit. The core then tries candidate flip patterns in ascending order of their rank sum, called the logistic weight. The syndrome of each candidate is the hard syndrome XORed with the single-flip syndromes of the flipped ranks. A single-flip syndrome is the parity-check column of that bit's position. A candidate whose result is zero is a codeword.

The parity-check columns sit in a small memory, and a write port can replace them at any time to change the code or the rate. Each clock cycle handles one weight. Weight 0 tests the hard syndrome on its own. For every weight w ≥ 1, the core tests in the same cycle the single flip of rank w, every two-part distinct partition of w, and every three-part distinct partition of w. A two-level priority selects the winning pattern. The ranks of that pattern are then mapped back to bit positions, and the corrected word is produced. If no pattern passes by the maximum weight, the core returns the hard word unchanged and raises a failure flag.

Top module: `nguess_search_core`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `word_out`, `weight_out` and `flips_out` are all zero.
- R2: When `h_we` is high on a clock edge, `h_col_data` replaces the parity-check column of bit position `h_addr`. A search started after the write uses the new column.
- R3: If `hard_syn` is zero, the search ends at weight 0 with `flips_out` = 0, and `word_out` equals `hard_word`.
- R4: Weight w is evaluated in the (w+1)-th cycle after the start edge, so `done` rises w+1 clock edges after the edge that accepted `start`. `weight_out` reports w.
- R5: The single flip of rank w is tested at weight w (for 1 ≤ w ≤ N). Rank r (1-based) maps to bit position `rank_pos[(r-1)*PW +: PW]`, and that bit is inverted in `word_out`.
- R6: Every pair of distinct ranks a > b ≥ 1 with a + b = w and a ≤ N is tested at weight w. A pass inverts both mapped bits, and `flips_out` = 2.
- R7: Every triple of distinct ranks a > b > c ≥ 1 with a + b + c = w and a ≤ N is tested at weight w. A pass inverts the three mapped bits, and `flips_out` = 3.
- R8: If several patterns of one weight pass, the winner has the fewest flips. Among pairs, the smaller low rank b wins. Among triples, the smaller c wins, then the smaller b.
- R9: If nothing passes up to and including weight `LW_MAX`, then `fail` = 1, `word_out` = `hard_word`, `weight_out` = `LW_MAX`, `flips_out` = 0, and `done` rises `LW_MAX`+1 edges after the start edge.
- R10: `start` has no effect while `busy` is high.
- R11: `done` is high for exactly one cycle per search. The result outputs hold until the next search ends.
- R12: The rank syndromes are captured when `start` is accepted. Column writes made during a search do not change that search's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_we | input | 1 | Parity-check column write enable |
| h_addr | input | PW | Bit position of the column to write |
| h_col_data | input | M | Column value (single-flip syndrome) |
| start | input | 1 | Begin a search when idle |
| hard_word | input | N | Hard-decision word |
| hard_syn | input | M | Syndrome of the hard-decision word |
| rank_pos | input | N*PW | Bit position of each rank, rank 1 in the lowest slice |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | No pattern found up to LW_MAX |
| word_out | output | N | Corrected word |
| weight_out | output | WW | Logistic weight at which the search ended |
| flips_out | output | 2 | Number of flipped bits in the chosen pattern |

## Verification
Some rules are checked on every cycle by the assertions:
- The search weight advances by exactly one per busy cycle.
- `done` is a single-cycle pulse.
- A failed search returns the latched hard word at the maximum weight.
- Writes to the column memory land.
- Each reported pattern has strictly ordered ranks that sum to the current weight.

Other behaviour depends on chosen column contents and permutations, so only the bench scenarios can show it:
- The search order across weights, and the exact latency.
- Tie-breaking between a single, a pair and a triple of the same weight.
- The mapping from ranks back to bit positions.
- The isolation of a running search from column writes and stray starts.

// File: rtl/nguess_pkg.sv
// Shared definitions for the noise-guess search core.
// Assumes nothing beyond IEEE 1800-2017.
package nguess_pkg;

    // Search controller state.
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } srch_state_e;

endpackage

// File: rtl/ng_col_store.sv
// Parity-check column memory: one M-bit single-flip syndrome for each bit
// position. It can be written at any time, and all columns are readable in
// parallel. Assumes h_addr < N.
module ng_col_store #(
    parameter int N  = 16,
    parameter int M  = 6,
    localparam int PW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [PW-1:0]          addr,
    input  logic [M-1:0]           wdata,
    output logic [N-1:0][M-1:0]    cols
);

    // Column write port, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cols <= '0;
        end else if (we) begin
            cols[addr] <= wdata;
        end
    end

    // R2
    col_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) && $past(rst_n) |-> cols[$past(addr)] == $past(wdata));

endmodule

// File: rtl/ng_rank_latch.sv
// Captures the single-flip syndrome of each reliability rank when a search
// starts: rank r+1 takes the column at position pos_in[r]. The search then
// runs on this snapshot, whatever the column memory does meanwhile.
module ng_rank_latch #(
    parameter int N  = 16,
    parameter int M  = 6,
    localparam int PW = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [N-1:0][M-1:0]    cols,
    input  logic [N-1:0][PW-1:0]   pos_in,
    output logic [N-1:0][M-1:0]    rank_syn
);

    // One gather multiplexer per rank, loaded at search start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_syn <= '0;
        end else if (load) begin
            for (int r = 0; r < N; r++) begin
                rank_syn[r] <= cols[pos_in[r]];
            end
        end
    end

    // R12
    snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rank_syn));

endmodule

// File: rtl/ng_pattern_tester.sv
// Combinational test of every 0/1/2/3-part distinct partition of the current
// weight w. Each candidate XORs the base syndrome with the rank syndromes of
// its parts; a zero result is a pass. A two-level priority picks the winner:
// fewest parts first; pairs by ascending low rank; triples by ascending
// smallest rank, then ascending middle rank. Ranks are 1-based.
module ng_pattern_tester #(
    parameter int N  = 16,
    parameter int M  = 6,
    parameter int WW = 5,
    localparam int RW = $clog2(N + 1),
    localparam int AW = ((WW > RW) ? WW : RW) + 2
) (
    input  logic [WW-1:0]          w,
    input  logic [M-1:0]           base,
    input  logic [N-1:0][M-1:0]    rank_syn,
    output logic                   hit,
    output logic [1:0]             parts,
    output logic [RW-1:0]          r_hi,
    output logic [RW-1:0]          r_mid,
    output logic [RW-1:0]          r_lo
);

    // Syndrome of a 1-based rank, zero when the rank is out of range.
    function automatic logic [M-1:0] syn_at(input logic [AW-1:0] rank,
                                            input logic [N-1:0][M-1:0] rs);
        logic [M-1:0] s;
        s = '0;
        for (int r = 1; r <= N; r++) begin
            if (rank == AW'(r)) s = rs[r-1];
        end
        return s;
    endfunction

    logic              zero_ok;
    logic              single_ok;
    logic [AW-1:0]     pair_a  [N-1];
    logic [N-2:0]      pair_ok;
    logic [AW-1:0]     trip_a  [N][N];
    logic              trip_ok [N][N];

    // Weight 0 and single-flip candidates.
    assign zero_ok   = (w == '0) && (base == '0);
    assign single_ok = (w != '0) && (AW'(w) <= AW'(N)) &&
                       ((base ^ syn_at(AW'(w), rank_syn)) == '0);

    // Pairs: low rank b fixed per lane, high rank a = w - b.
    for (genvar b = 1; b < N; b++) begin : g_pair
        assign pair_a[b-1]  = AW'(w) - AW'(b);
        assign pair_ok[b-1] = (pair_a[b-1] > AW'(b)) && (pair_a[b-1] <= AW'(N)) &&
                              ((base ^ rank_syn[b-1] ^ syn_at(pair_a[b-1], rank_syn)) == '0);
    end

    // Triples: lane (b, c) with c < b, high rank a = w - b - c.
    for (genvar bi = 0; bi < N; bi++) begin : g_trip_b
        for (genvar ci = 0; ci < N; ci++) begin : g_trip_c
            if (ci < bi) begin : g_live
                assign trip_a[bi][ci]  = AW'(w) - AW'(bi + 1) - AW'(ci + 1);
                assign trip_ok[bi][ci] = (trip_a[bi][ci] > AW'(bi + 1)) &&
                                         (trip_a[bi][ci] <= AW'(N)) &&
                                         ((base ^ rank_syn[bi] ^ rank_syn[ci] ^
                                           syn_at(trip_a[bi][ci], rank_syn)) == '0);
            end else begin : g_dead
                assign trip_a[bi][ci]  = '0;
                assign trip_ok[bi][ci] = 1'b0;
            end
        end
    end

    // Two-level priority encoder over the pass flags.
    always_comb begin
        hit   = 1'b0;
        parts = 2'd0;
        r_hi  = '0;
        r_mid = '0;
        r_lo  = '0;
        if (zero_ok) begin
            hit = 1'b1;
        end else if (single_ok) begin
            hit   = 1'b1;
            parts = 2'd1;
            r_hi  = RW'(w);
        end else begin
            for (int b = 1; b < N; b++) begin
                if (!hit && pair_ok[b-1]) begin
                    hit   = 1'b1;
                    parts = 2'd2;
                    r_hi  = pair_a[b-1][RW-1:0];
                    r_mid = RW'(b);
                end
            end
            for (int c = 0; c < N; c++) begin
                for (int b = 0; b < N; b++) begin
                    if (!hit && trip_ok[b][c]) begin
                        hit   = 1'b1;
                        parts = 2'd3;
                        r_hi  = trip_a[b][c][RW-1:0];
                        r_mid = RW'(b + 1);
                        r_lo  = RW'(c + 1);
                    end
                end
            end
        end
    end

    // Checks on the reported pattern: ordered ranks summing to the weight.
    always_comb begin
        if (hit && parts == 2'd2) begin
            // R6
            pair_form_chk: assert (r_mid < r_hi && int'(r_hi) + int'(r_mid) == int'(w));
        end
        if (hit && parts == 2'd3) begin
            // R7
            trip_form_chk: assert (r_lo < r_mid && r_mid < r_hi &&
                                   int'(r_hi) + int'(r_mid) + int'(r_lo) == int'(w));
        end
    end

endmodule

// File: rtl/ng_search_ctrl.sv
// Search sequencer. It accepts start when idle, latches the hard word,
// syndrome and rank map, then steps the weight once per cycle from 0. On a
// pass it builds the corrected word by mapping ranks to bit positions; after
// LW_MAX without a pass it reports failure with the hard word unchanged.
module ng_search_ctrl
    import nguess_pkg::*;
#(
    parameter int N      = 16,
    parameter int M      = 6,
    parameter int LW_MAX = 24,
    localparam int PW = $clog2(N),
    localparam int RW = $clog2(N + 1),
    localparam int WW = $clog2(LW_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [N-1:0]           hard_word,
    input  logic [M-1:0]           hard_syn,
    input  logic [N-1:0][PW-1:0]   pos_in,
    input  logic                   hit,
    input  logic [1:0]             parts,
    input  logic [RW-1:0]          r_hi,
    input  logic [RW-1:0]          r_mid,
    input  logic [RW-1:0]          r_lo,
    output logic                   load,
    output logic [WW-1:0]          w,
    output logic [M-1:0]           base,
    output logic                   busy,
    output logic                   done,
    output logic                   fail,
    output logic [N-1:0]           word_out,
    output logic [WW-1:0]          weight_out,
    output logic [1:0]             flips_out
);

    srch_state_e               state;
    logic [N-1:0]              hard_q;
    logic [N-1:0][PW-1:0]      pos_q;
    logic [N-1:0]              flip_mask;

    // One-hot of the bit position that holds a 1-based rank.
    function automatic logic [N-1:0] rank_bit(input logic [RW-1:0] rank,
                                              input logic [N-1:0][PW-1:0] pq);
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) begin
            if (rank == RW'(i + 1)) m[pq[i]] = 1'b1;
        end
        return m;
    endfunction

    assign load = start && (state == ST_IDLE);
    assign busy = (state == ST_SEARCH);

    // Flip mask of the selected pattern, one multiplexer per flipped bit.
    always_comb begin
        flip_mask = '0;
        if (parts >= 2'd1) flip_mask = flip_mask ^ rank_bit(r_hi, pos_q);
        if (parts >= 2'd2) flip_mask = flip_mask ^ rank_bit(r_mid, pos_q);
        if (parts == 2'd3) flip_mask = flip_mask ^ rank_bit(r_lo, pos_q);
    end

    // Sequencer: latch at start, step weight, publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            w          <= '0;
            base       <= '0;
            hard_q     <= '0;
            pos_q      <= '0;
            done       <= 1'b0;
            fail       <= 1'b0;
            word_out   <= '0;
            weight_out <= '0;
            flips_out  <= 2'd0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        hard_q <= hard_word;
                        base   <= hard_syn;
                        pos_q  <= pos_in;
                        w      <= '0;
                        state  <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (hit) begin
                        word_out   <= hard_q ^ flip_mask;
                        fail       <= 1'b0;
                        weight_out <= w;
                        flips_out  <= parts;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else if (w == WW'(LW_MAX)) begin
                        word_out   <= hard_q;
                        fail       <= 1'b1;
                        weight_out <= w;
                        flips_out  <= 2'd0;
                        done       <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        w <= w + WW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    weight_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> w == $past(w) + WW'(1));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    fail_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && fail |-> word_out == hard_q && weight_out == WW'(LW_MAX) && flips_out == 2'd0);

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> hard_q == $past(hard_q) && base == $past(base));

    // R3
    zero_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fail && flips_out == 2'd0 |-> weight_out == '0 && word_out == hard_q);

endmodule

// File: rtl/nguess_search_core.sv
// Top of the noise-guess search core: column memory, rank snapshot,
// partition tester and sequencer. One weight per clock; not pipelined.
// Assumes rank_pos is a permutation of 0..N-1 and LW_MAX <= 3N-3.
module nguess_search_core #(
    parameter int N      = 16,
    parameter int M      = 6,
    parameter int LW_MAX = 24,
    localparam int PW = $clog2(N),
    localparam int RW = $clog2(N + 1),
    localparam int WW = $clog2(LW_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic [PW-1:0]     h_addr,
    input  logic [M-1:0]      h_col_data,
    input  logic              start,
    input  logic [N-1:0]      hard_word,
    input  logic [M-1:0]      hard_syn,
    input  logic [N*PW-1:0]   rank_pos,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [N-1:0]      word_out,
    output logic [WW-1:0]     weight_out,
    output logic [1:0]        flips_out
);

    logic [N-1:0][PW-1:0]  pos_in;
    logic [N-1:0][M-1:0]   cols;
    logic [N-1:0][M-1:0]   rank_syn;
    logic                  load;
    logic [WW-1:0]         w;
    logic [M-1:0]          base;
    logic                  hit;
    logic [1:0]            parts;
    logic [RW-1:0]         r_hi;
    logic [RW-1:0]         r_mid;
    logic [RW-1:0]         r_lo;

    assign pos_in = rank_pos;

    ng_col_store #(.N(N), .M(M)) u_cols (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (h_we),
        .addr  (h_addr),
        .wdata (h_col_data),
        .cols  (cols)
    );

    ng_rank_latch #(.N(N), .M(M)) u_ranks (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cols     (cols),
        .pos_in   (pos_in),
        .rank_syn (rank_syn)
    );

    ng_pattern_tester #(.N(N), .M(M), .WW(WW)) u_test (
        .w        (w),
        .base     (base),
        .rank_syn (rank_syn),
        .hit      (hit),
        .parts    (parts),
        .r_hi     (r_hi),
        .r_mid    (r_mid),
        .r_lo     (r_lo)
    );

    ng_search_ctrl #(.N(N), .M(M), .LW_MAX(LW_MAX)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .hard_word  (hard_word),
        .hard_syn   (hard_syn),
        .pos_in     (pos_in),
        .hit        (hit),
        .parts      (parts),
        .r_hi       (r_hi),
        .r_mid      (r_mid),
        .r_lo       (r_lo),
        .load       (load),
        .w          (w),
        .base       (base),
        .busy       (busy),
        .done       (done),
        .fail       (fail),
        .word_out   (word_out),
        .weight_out (weight_out),
        .flips_out  (flips_out)
    );

endmodule

// File: tb/tb_nguess_search_core.sv
`timescale 1ns/1ps
module tb_nguess_search_core;

    localparam int N  = 16;
    localparam int M  = 6;
    localparam int LW = 24;
    localparam int PW = $clog2(N);
    localparam int WW = $clog2(LW + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              h_we = 1'b0;
    logic [PW-1:0]     h_addr = '0;
    logic [M-1:0]      h_col_data = '0;
    logic              start = 1'b0;
    logic [N-1:0]      hard_word = '0;
    logic [M-1:0]      hard_syn = '0;
    logic [N*PW-1:0]   rank_pos = '0;
    logic              busy, done, fail;
    logic [N-1:0]      word_out;
    logic [WW-1:0]     weight_out;
    logic [1:0]        flips_out;

    nguess_search_core #(.N(N), .M(M), .LW_MAX(LW)) dut (
        .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr),
        .h_col_data(h_col_data), .start(start), .hard_word(hard_word),
        .hard_syn(hard_syn), .rank_pos(rank_pos), .busy(busy), .done(done),
        .fail(fail), .word_out(word_out), .weight_out(weight_out),
        .flips_out(flips_out)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [N-1:0] word;
        logic         fl;
        int           weight;
        int           flips;
        int           cycles;
        int           start_cyc;
        string        tag;
    } exp_t;

    exp_t        sb[$];
    logic [M-1:0] hcols [N];
    int           pos [N];
    int unsigned  seed = 32'h1234_5678;

    function automatic int unsigned rnd();
        seed = seed * 1103515245 + 12345;
        return seed >> 8;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop and compare each result as done appears.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(word_out === e.word, e.tag, "word", word_out, e.word);
                check(fail === e.fl, e.tag, "fail", fail, e.fl);
                check(int'(weight_out) == e.weight, e.tag, "weight", weight_out, e.weight);
                check(int'(flips_out) == e.flips, e.tag, "flips", flips_out, e.flips);
                check(cyc - e.start_cyc == e.cycles, "R4", {e.tag, " latency"},
                      cyc - e.start_cyc, e.cycles);
            end
        end
    end

    task automatic write_col(input int p, input logic [M-1:0] v);
        @(negedge clk);
        h_we = 1'b1; h_addr = PW'(p); h_col_data = v;
        hcols[p] = v;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic set_pos(input bit ident);
        for (int i = 0; i < N; i++) begin
            pos[i] = ident ? i : (5 * i + 3) % N;
            rank_pos[i*PW +: PW] = PW'(pos[i]);
        end
    endtask

    function automatic logic [M-1:0] rsyn(input int r);
        return hcols[pos[r-1]];
    endfunction

    // Reference search built from the requirements.
    task automatic ref_search(input logic [M-1:0] syn, input logic [N-1:0] hard,
                              output exp_t e);
        bit found = 1'b0;
        e.word = hard; e.fl = 1'b1; e.weight = LW; e.flips = 0; e.cycles = LW + 1;
        for (int w = 0; w <= LW && !found; w++) begin
            if (w == 0 && syn == '0) begin
                found = 1'b1; e.flips = 0;
            end else if (w >= 1 && w <= N && (syn ^ rsyn(w)) == '0) begin
                found = 1'b1; e.flips = 1; e.word = hard ^ (N'(1) << pos[w-1]);
            end
            for (int b = 1; b < N && !found; b++) begin
                int a = w - b;
                if (a > b && a <= N && (syn ^ rsyn(a) ^ rsyn(b)) == '0) begin
                    found = 1'b1; e.flips = 2;
                    e.word = hard ^ (N'(1) << pos[a-1]) ^ (N'(1) << pos[b-1]);
                end
            end
            for (int c = 1; c <= N && !found; c++) begin
                for (int b = c + 1; b <= N && !found; b++) begin
                    int a = w - b - c;
                    if (a > b && a <= N && (syn ^ rsyn(a) ^ rsyn(b) ^ rsyn(c)) == '0) begin
                        found = 1'b1; e.flips = 3;
                        e.word = hard ^ (N'(1) << pos[a-1]) ^ (N'(1) << pos[b-1]) ^
                                 (N'(1) << pos[c-1]);
                    end
                end
            end
            if (found) begin
                e.fl = 1'b0; e.weight = w; e.cycles = w + 1;
            end
        end
    endtask

    function automatic logic [M-1:0] syn_of(input logic [N-1:0] wd);
        logic [M-1:0] s = '0;
        for (int i = 0; i < N; i++) if (wd[i]) s ^= hcols[i];
        return s;
    endfunction

    // Driver: start a search and push the expected result.
    task automatic run(input logic [N-1:0] hard, input logic [M-1:0] syn,
                       input exp_t e, input string tag);
        @(negedge clk);
        hard_word = hard; hard_syn = syn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.start_cyc = cyc;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_done();
        do @(posedge clk); while (!done);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_expect(input logic [N-1:0] hard, input logic [M-1:0] syn,
                              input logic [N-1:0] wd, input bit fl, input int wt,
                              input int fp, input string tag);
        exp_t e;
        e.word = wd; e.fl = fl; e.weight = wt; e.flips = fp; e.cycles = wt + 1;
        run(hard, syn, e, tag);
        wait_done();
    endtask

    initial begin
        for (int i = 0; i < N; i++) hcols[i] = '0;
        set_pos(1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && fail == 0, "R1", "flags", {busy, done, fail}, 0);
        check(word_out == 0 && weight_out == 0 && flips_out == 0, "R1", "result",
              word_out, 0);

        // R3: zero syndrome ends at weight 0
        run_expect(16'hA5C3, '0, 16'hA5C3, 1'b0, 0, 0, "R3");

        // R9 with R10 and R12: all-zero columns never pass
        begin
            exp_t e;
            e.word = 16'h0F0F; e.fl = 1'b1; e.weight = LW; e.flips = 0; e.cycles = LW + 1;
            run(16'h0F0F, 6'h01, e, "R9");
            repeat (3) @(negedge clk);
            hard_word = 16'hFFFF; hard_syn = '0; start = 1'b1;   // R10 stray start
            @(negedge clk);
            start = 1'b0;
            write_col(0, 6'h01);                                 // R12 write mid-search
            wait_done();
            check(busy == 0, "R10", "busy after run", busy, 0);
        end

        // R2: the column written above now serves rank 1
        run_expect(16'h0000, 6'h01, 16'h0001, 1'b0, 1, 1, "R2");

        // R5: rank r has syndrome r, mapped through a non-identity permutation
        set_pos(1'b0);
        for (int r = 1; r <= N; r++) write_col(pos[r-1], M'(r));
        run_expect(16'h3C00, 6'd7, 16'h3C00 ^ (N'(1) << pos[6]), 1'b0, 7, 1, "R5");

        // R8: single beats pair at equal weight, then lower pair rank wins
        set_pos(1'b1);
        write_col(0, 6'd1); write_col(1, 6'd2); write_col(2, 6'd4);
        write_col(3, 6'd7); write_col(4, 6'd6);
        run_expect(16'h8001, 6'd6, 16'h8001 ^ 16'h0010, 1'b0, 5, 1, "R8");
        write_col(4, 6'h38);
        run_expect(16'h8001, 6'd6, 16'h8001 ^ 16'h0009, 1'b0, 5, 2, "R8");

        // R6/R7: random columns, injected 1..3 bit errors on codeword 0
        set_pos(1'b0);
        for (int t = 0; t < 24; t++) begin
            exp_t e;
            logic [N-1:0] hw;
            for (int i = 0; i < N; i++) write_col(i, M'((rnd() % 63) + 1));
            hw = '0;
            for (int k = 0; k <= (t % 3); k++) hw[rnd() % N] = 1'b1;
            ref_search(syn_of(hw), hw, e);
            run(hw, syn_of(hw), e, "R6/R7");
            wait_done();
            check(syn_of(word_out) == '0 || fail, "R6/R7", "corrected syndrome",
                  syn_of(word_out), 0);
        end

        // R11: outputs hold after done
        repeat (3) @(negedge clk);
        check(done == 0 && sb.size() == 0, "R11", "idle hold", done, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule